// File: doc/BRIEF.md
# Shadow Stack Enable Hierarchy

This block keeps the three shadow-stack enable bits that live in the machine, hypervisor and supervisor environment-configuration registers, and applies the rules that couple them. A bit at a lower level can only be stored as one while every level above it is enabled. A read of a lower-level register shows the bit as zero while any level above it is off, even if a one is still stored underneath. Software reaches the bits through a small CSR port. Writes take effect on the clock edge. A read is requested with a strobe, and its data appears on the following cycle.

From the stored bits the block derives one live enable for each privilege mode below machine mode: supervisor, user, virtual supervisor and virtual user. Instruction decode and exception logic elsewhere in the core use these enables. A build-time parameter states whether the shadow stack extension exists. Without it, every enable bit is a constant zero that cannot be written.

Top module: `sse_enable_hier`

## Requirements
- R1: After synchronous reset all stored enable bits are 0, all four mode enables are 0, and reads of the three registers return 0.
- R2: When the extension is implemented, the machine-level bit (register 0x30A, bit 3) stores bit 3 of any write to that address, and reads back at bit 3.
- R3: A write to the hypervisor register (0x60A) stores zero in its enable bit while the machine-level bit is 0; otherwise it stores bit 3 of the write data.
- R4: A write to the supervisor register (0x10A) stores zero in its enable bit while either the machine-level or the hypervisor-level bit is 0; otherwise it stores bit 3 of the write data.
- R5: A read of 0x60A returns bit 3 as zero while the machine-level bit is 0. A stored one becomes visible again once the machine-level bit returns to 1.
- R6: A read of 0x10A returns bit 3 as zero while the machine-level or the hypervisor-level bit is 0.
- R7: The mode enables are: supervisor = M; virtual supervisor = M and H; user = M and S; virtual user = M and H and S, where M, H and S are the stored bits.
- R8: Every read data bit other than bit 3 is zero. A read of any other address returns zero, and a write to any other address changes no enable.
- R9: Read data is registered. It is valid in the cycle after the read strobe and is zero in any cycle that does not follow a strobe. A read issued in the same cycle as a write returns the state from before that write.
- R10: When the extension is not implemented, all three bits read as zero, ignore writes, and all mode enables stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | ADDR_W (12) | Register address for the current access |
| csr_we | input | 1 | Write enable |
| csr_wdata | input | XLEN (64) | Write data; only bit 3 is used |
| csr_re | input | 1 | Read strobe |
| csr_rdata | output | XLEN (64) | Read data, one cycle after the strobe |
| en_s | output | 1 | Shadow stack enabled in supervisor mode |
| en_u | output | 1 | Shadow stack enabled in user mode |
| en_vs | output | 1 | Shadow stack enabled in virtual supervisor mode |
| en_vu | output | 1 | Shadow stack enabled in virtual user mode |

## Verification
Some properties are checked by assertions on every cycle. A hypervisor or supervisor bit may only rise while the levels above it were enabled. The virtual user enable implies both the virtual supervisor and user enables, and every mode enable drops when the supervisor enable is 0. Read data is clean outside bit 3 and is zero when no read was requested. Other behaviours can only be shown by the bench's scenarios. These include a stored hypervisor bit reappearing after the machine bit is toggled, a same-cycle read returning the state from before the write, writes to foreign addresses having no effect, and the unimplemented build ignoring all writes. The bench covers them with directed steps, followed by a long pseudo-random sweep that checks against an arithmetic model.

// File: rtl/sse_pkg.sv
package sse_pkg;

    localparam int ENABLE_BIT = 3;
    localparam int CFG_ADDR_W = 12;

    localparam logic [CFG_ADDR_W-1:0] MACH_CFG_ADDR = 12'h30A;
    localparam logic [CFG_ADDR_W-1:0] HYP_CFG_ADDR  = 12'h60A;
    localparam logic [CFG_ADDR_W-1:0] SUP_CFG_ADDR  = 12'h10A;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MACH = 2'd1,
        SEL_HYP  = 2'd2,
        SEL_SUP  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic mach;
        logic hyp;
        logic sup;
    } sse_state_t;

    typedef struct packed {
        logic s;
        logic u;
        logic vs;
        logic vu;
    } sse_mode_en_t;

    // View of the stored bits as software sees them on a read.
    function automatic sse_state_t read_view(input sse_state_t st);
        sse_state_t v;
        v.mach = st.mach;
        v.hyp  = st.mach & st.hyp;
        v.sup  = st.mach & st.hyp & st.sup;
        return v;
    endfunction

    // Per-mode enables derived from the stored bits.
    function automatic sse_mode_en_t mode_enables(input sse_state_t st);
        sse_mode_en_t e;
        e.s  = st.mach;
        e.vs = st.mach & st.hyp;
        e.u  = st.mach & st.sup;
        e.vu = st.mach & st.hyp & st.sup;
        return e;
    endfunction

endpackage

// File: rtl/sse_addr_decode.sv
module sse_addr_decode
    import sse_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output cfg_sel_e          sel
);
    always_comb begin
        if (addr == ADDR_W'(MACH_CFG_ADDR)) begin
            sel = SEL_MACH;
        end else if (addr == ADDR_W'(HYP_CFG_ADDR)) begin
            sel = SEL_HYP;
        end else if (addr == ADDR_W'(SUP_CFG_ADDR)) begin
            sel = SEL_SUP;
        end else begin
            sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/sse_enable_regs.sv
module sse_enable_regs
    import sse_pkg::*;
#(
    parameter bit IMPL = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  cfg_sel_e   sel,
    input  logic       wbit,
    output sse_state_t st
);
    generate
        if (IMPL) begin : g_impl
            sse_state_t st_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q <= '0;
                end else if (wr_en) begin
                    case (sel)
                        SEL_MACH: st_q.mach <= wbit;
                        SEL_HYP:  st_q.hyp  <= wbit & st_q.mach;
                        SEL_SUP:  st_q.sup  <= wbit & st_q.mach & st_q.hyp;
                        default:  ;
                    endcase
                end
            end

            assign st = st_q;

            p_hyp_gated_r3: assert property (@(posedge clk) disable iff (rst)
                $rose(st_q.hyp) |-> $past(st_q.mach));

            p_sup_gated_r4: assert property (@(posedge clk) disable iff (rst)
                $rose(st_q.sup) |-> ($past(st_q.mach) && $past(st_q.hyp)));

            p_hyp_write_held_r3: assert property (@(posedge clk) disable iff (rst)
                (wr_en && sel == SEL_HYP && !st_q.mach) |=> !st_q.hyp);
        end else begin : g_none
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst, wr_en, sel, wbit};
            assign st = '0;
        end
    endgenerate
endmodule

// File: rtl/sse_read_port.sv
module sse_read_port
    import sse_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_en,
    input  cfg_sel_e        sel,
    input  sse_state_t      st,
    output logic [XLEN-1:0] rdata
);
    localparam logic [XLEN-1:0] BIT_MASK = XLEN'(1) << ENABLE_BIT;

    sse_state_t      vis;
    logic            sel_bit;
    logic [XLEN-1:0] rdata_d;

    always_comb begin
        vis = read_view(st);
        case (sel)
            SEL_MACH: sel_bit = vis.mach;
            SEL_HYP:  sel_bit = vis.hyp;
            SEL_SUP:  sel_bit = vis.sup;
            default:  sel_bit = 1'b0;
        endcase
        rdata_d = '0;
        rdata_d[ENABLE_BIT] = sel_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rdata_d;
        end else begin
            rdata <= '0;
        end
    end

    p_clean_bits_r8: assert property (@(posedge clk) disable iff (rst)
        (rdata & ~BIT_MASK) == '0);

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rdata == '0));

    p_hyp_read_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_HYP && !st.mach) |=> (rdata == '0));
endmodule

// File: rtl/sse_enable_hier.sv
module sse_enable_hier
    import sse_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int ADDR_W = 12,
    parameter bit IMPL   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_we,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic              csr_re,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              en_s,
    output logic              en_u,
    output logic              en_vs,
    output logic              en_vu
);
    cfg_sel_e     sel;
    sse_state_t   st;
    sse_mode_en_t men;
    logic         unused_wdata;

    assign unused_wdata = ^csr_wdata;

    sse_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (csr_addr),
        .sel  (sel)
    );

    sse_enable_regs #(.IMPL(IMPL)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (csr_we),
        .sel   (sel),
        .wbit  (csr_wdata[ENABLE_BIT]),
        .st    (st)
    );

    sse_read_port #(.XLEN(XLEN)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd_en (csr_re),
        .sel   (sel),
        .st    (st),
        .rdata (csr_rdata)
    );

    assign men   = mode_enables(st);
    assign en_s  = men.s;
    assign en_u  = men.u;
    assign en_vs = men.vs;
    assign en_vu = men.vu;

    p_vu_nested_r7: assert property (@(posedge clk) disable iff (rst)
        en_vu |-> (en_vs && en_u));

    p_s_gates_all_r7: assert property (@(posedge clk) disable iff (rst)
        !en_s |-> !(en_u || en_vs || en_vu));

    p_mach_write_r2: assert property (@(posedge clk) disable iff (rst)
        (IMPL && csr_we && csr_addr == ADDR_W'(MACH_CFG_ADDR))
            |=> (en_s == $past(csr_wdata[ENABLE_BIT])));
endmodule

// File: tb/tb_sse_enable_hier.sv
module tb_sse_enable_hier;
    localparam int XLEN = 64;
    localparam int AW   = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [AW-1:0]   csr_addr = '0;
    logic            csr_we = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic            csr_re = 1'b0;
    logic [XLEN-1:0] rd_i, rd_n;
    logic            s_i, u_i, vs_i, vu_i, s_n, u_n, vs_n, vu_n;

    int checks = 0;
    int failures = 0;
    logic m = 1'b0, h = 1'b0, s = 1'b0;

    always #5 clk = ~clk;

    sse_enable_hier #(.XLEN(XLEN), .ADDR_W(AW), .IMPL(1'b1)) dut (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_re(csr_re), .csr_rdata(rd_i),
        .en_s(s_i), .en_u(u_i), .en_vs(vs_i), .en_vu(vu_i));

    sse_enable_hier #(.XLEN(XLEN), .ADDR_W(AW), .IMPL(1'b0)) dut_ni (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_re(csr_re), .csr_rdata(rd_n),
        .en_s(s_n), .en_u(u_n), .en_vs(vs_n), .en_vu(vu_n));

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] exp_read(input logic [AW-1:0] a);
        logic b;
        case (a)
            12'h30A: b = m;
            12'h60A: b = m & h;
            12'h10A: b = m & h & s;
            default: b = 1'b0;
        endcase
        return XLEN'(b) << 3;
    endfunction

    function automatic void model_write(input logic [AW-1:0] a, input logic [XLEN-1:0] d);
        case (a)
            12'h30A: m = d[3];
            12'h60A: h = d[3] & m;
            12'h10A: s = d[3] & m & h;
            default: ;
        endcase
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input logic [XLEN-1:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_read(input string req, input logic [AW-1:0] a);
        @(negedge clk);
        csr_addr = a; csr_re = 1'b1;
        @(negedge clk);
        csr_re = 1'b0;
        chk(req, rd_i, exp_read(a));
        chk({req, "/R10"}, rd_n, '0);
    endtask

    task automatic chk_en(input string req);
        chk({req, "/R7 modes"}, XLEN'({s_i, u_i, vs_i, vu_i}),
            XLEN'({m, m & s, m & h, m & h & s}));
        chk({req, "/R10 modes"}, XLEN'({s_n, u_n, vs_n, vu_n}), '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [AW-1:0] addrs [4];
        addrs[0] = 12'h30A; addrs[1] = 12'h60A; addrs[2] = 12'h10A; addrs[3] = 12'h7C0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 modes", XLEN'({s_i, u_i, vs_i, vu_i}), '0);
        do_read("R1 mach", 12'h30A);
        do_read("R1 hyp", 12'h60A);
        do_read("R1 sup", 12'h10A);

        // R3/R4: lower bits blocked while machine bit is 0
        do_write(12'h60A, 64'h8);
        do_write(12'h10A, 64'h8);
        do_write(12'h30A, 64'h8);
        do_read("R3 hyp blocked", 12'h60A);
        do_read("R4 sup blocked", 12'h10A);
        chk("R3 vs off", XLEN'(vs_i), '0);

        // R2/R8: machine bit with all-ones write data
        do_write(12'h30A, '1);
        do_read("R2/R8 mach", 12'h30A);
        chk("R2 mach bit", rd_i, 64'h8);
        do_write(12'h10A, 64'h8);
        do_read("R4 sup blocked by hyp", 12'h10A);
        do_write(12'h60A, 64'h8);
        do_write(12'h10A, 64'h8);
        do_read("R6 sup visible", 12'h10A);
        chk("R6 sup bit", rd_i, 64'h8);
        chk_en("R7 all on");
        chk("R7 vu on", XLEN'(vu_i), 64'h1);

        // R5/R6: machine off hides, machine on reveals
        do_write(12'h30A, 64'h0);
        do_read("R5 hyp masked", 12'h60A);
        do_read("R6 sup masked", 12'h10A);
        chk_en("R7 mach off");
        do_write(12'h30A, 64'h8);
        do_read("R5 hyp reappears", 12'h60A);
        chk("R5 hyp bit", rd_i, 64'h8);
        do_write(12'h60A, 64'h0);
        do_read("R6 sup masked by hyp", 12'h10A);
        chk("R7 u stays", XLEN'(u_i), 64'h1);

        // R8: foreign address
        do_write(12'h7C0, '1);
        chk_en("R8 foreign write");
        do_read("R8 foreign read", 12'h7C0);

        // R9: same-cycle read and write returns old state, then idle zero
        @(negedge clk);
        csr_addr = 12'h30A; csr_wdata = '0; csr_we = 1'b1; csr_re = 1'b1;
        @(negedge clk);
        csr_we = 1'b0; csr_re = 1'b0;
        chk("R9 old value", rd_i, 64'h8);
        model_write(12'h30A, '0);
        @(negedge clk);
        chk("R9 idle zero", rd_i, '0);
        chk_en("R9 after write");

        // Sweep
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            logic [XLEN-1:0] d;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            d = {lfsr, lfsr, lfsr, lfsr};
            d[3] = (lfsr[7:6] != 2'b00);
            do_write(addrs[lfsr[1:0]], d);
            chk_en("R7 sweep");
            do_read("R5/R6 sweep read", addrs[lfsr[3:2]]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule